// File: doc/BRIEF.md
# On-Screen Display Serial Command Decoder

This block is the control front end of a character overlay engine. A host sends a stream of bytes over a three-wire serial link (an active-low select, a serial clock and a data line). The block oversamples the link in its own clock domain and turns the stream into 8-bit bytes. It then interprets each byte as either a command identifier or a data byte for the command currently selected. Character-write traffic goes to the write port of an external 12-row by 24-column character memory, and each write carries a row, a column, two attribute bits and a 7-bit character code. Everything else is stored in a small set of control registers that the raster side of the overlay reads.

The block also holds a fill sequencer. On request, it writes the blank code into every cell of the character memory, one cell per clock, while character display is switched off. Four video-standard mode bits from the control registers are merged with four external strap pins to form the effective mode.

Top module: `osd_cmd_if`

## Requirements
- R1: A bit is taken only on a rising edge of `sclk_i` while `cs_i` is low. Bits are shifted in most-significant first, and eight bits form one byte. When `cs_i` goes high, a byte that is only partly received is discarded, so the next byte starts fresh.
- R2: A byte with bit 7 = 1 is an identifier whose bits 6:4 select command 0 to 7. A byte with bit 7 = 0 is data for the command most recently selected, and that selection stays in place for any number of following data bytes.
- R3: In the command-0 identifier, bits 3:0 set the row address. In a command-0 data byte, bits 4:0 set the column address.
- R4: In the command-1 identifier, bit 1 sets attribute 2 and bit 0 sets attribute 1, presented on `mem_attr_o[1]` and `mem_attr_o[0]`. Each command-1 data byte causes one memory write of code = byte[6:0] at the current row and column. `mem_we_o` is high for one cycle, two clock cycles after the rising `sclk_i` edge that completed the byte.
- R5: Once the command-1 identifier has been taken, every later byte, including bytes with bit 7 = 1, is written as character data (code = byte[6:0]). This lasts until `cs_i` rises.
- R6: A rising edge on `cs_i` returns the command selection to command 0.
- R7: After each character write the column increases by one. Column 23 wraps to column 0 of the next row, and row 11 wraps to row 0.
- R8: While the row is above 11 or the column is above 23, a character data byte issues no memory write and leaves the address unchanged. `mem_we_o` never presents an out-of-range address.
- R9: For command k in 2..7, the identifier's bits 3:0 are stored in `ctl_hdr_o[4(k-2)+3 : 4(k-2)]` and each data byte's bits 6:0 are stored in `ctl_dat_o[7(k-2)+6 : 7(k-2)]`.
- R10: `rst_ni` low clears every register. A command-4 identifier with bit 3 = 1 also clears every register, including the command selection and any pending fill.
- R11: A command-4 identifier with bit 2 = 1 requests a fill. The fill writes code 0x7F with attributes 0 to all 288 cells, row-major, one cell per clock. It runs only while command-4 data bit 0 (display on) is 0, and it pauses without losing its place otherwise. It gives way to a character write in the same cycle. When the fill ends, bit 2 of the command-4 identifier register clears.
- R12: `mode_o` is the bitwise OR of the command-6 identifier bits 3:0 and `mode_pin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial bit clock, sampled by clk_i |
| sdi_i | input | 1 | Serial data |
| mode_pin_i | input | 4 | External video-standard strap pins |
| mem_we_o | output | 1 | Character memory write strobe |
| mem_row_o | output | 4 | Write row |
| mem_col_o | output | 5 | Write column |
| mem_attr_o | output | 2 | Write attributes {attr2, attr1} |
| mem_code_o | output | 7 | Write character code |
| ctl_hdr_o | output | 24 | Identifier nibbles of commands 2..7 |
| ctl_dat_o | output | 42 | Data fields of commands 2..7 |
| mode_o | output | 4 | Effective video-standard mode |

## Verification
The assertions assume that `cs_i`, `sclk_i` and `sdi_i` are already synchronous to `clk_i`, and that each level of `sclk_i` lasts at least one clock cycle, so every serial edge is seen exactly once. The stimulus changes these inputs only on falling edges of `clk_i` and holds each serial clock level for two cycles. The mode pins change only between transactions. Select is raised only between whole bytes, except in the deliberate partial-byte case. A character write is placed in the middle of a running fill so that the give-way path is exercised.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int unsigned NUM_ROWS = 12;
  localparam int unsigned NUM_COLS = 24;
  localparam int unsigned ROW_W    = $clog2(NUM_ROWS);
  localparam int unsigned COL_W    = $clog2(NUM_COLS);
  localparam int unsigned CODE_W   = 7;
  localparam int unsigned ATTR_W   = 2;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_CTL  = 6;
  localparam int unsigned HDR_W    = 4;
  localparam int unsigned DAT_W    = 7;

  localparam int unsigned SYS_SLOT  = 2;  // command 4
  localparam int unsigned MODE_SLOT = 4;  // command 6
  localparam int unsigned SOFT_RST_BIT = 3;
  localparam int unsigned FILL_BIT     = 2;
  localparam int unsigned DISP_BIT     = 0;
  localparam logic [CODE_W-1:0] BLANK_CODE = '1;

  typedef enum logic [2:0] {
    CMD_ADDR = 3'd0,
    CMD_CHAR = 3'd1,
    CMD_C2   = 3'd2,
    CMD_C3   = 3'd3,
    CMD_C4   = 3'd4,
    CMD_C5   = 3'd5,
    CMD_C6   = 3'd6,
    CMD_C7   = 3'd7
  } cmd_e;

  typedef struct packed {
    logic              we;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [ATTR_W-1:0] attr;
    logic [CODE_W-1:0] code;
  } mem_wr_t;
endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx
  import osd_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              cs_rise_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic              cs_q, sclk_q, vld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, byte_q;
  logic              take;
  logic [BYTE_W-1:0] sh_nxt;

  assign take   = !cs_i && sclk_i && !sclk_q;
  assign sh_nxt = {sh_q[BYTE_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
    end else begin
      cs_q   <= cs_i;
      sclk_q <= sclk_i;
      vld_q  <= 1'b0;
      if (cs_i) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q <= sh_nxt;
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          cnt_q  <= '0;
          vld_q  <= 1'b1;
          byte_q <= sh_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign cs_rise_o  = cs_i && !cs_q;

  AST_PARTIAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |=> cnt_q == '0); // R1
  AST_BYTE_UNDER_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(!cs_i)); // R1
endmodule

// File: rtl/osd_cmd_dec.sv
module osd_cmd_dec
  import osd_cmd_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               byte_vld_i,
  input  logic [BYTE_W-1:0]                  byte_i,
  input  logic                               cs_rise_i,
  input  logic                               fill_done_i,
  output mem_wr_t                            wr_o,
  output logic [NUM_CTL-1:0][HDR_W-1:0]      hdr_o,
  output logic [NUM_CTL-1:0][DAT_W-1:0]      dat_o
);
  cmd_e              cmd_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [ATTR_W-1:0] attr_q;
  logic [NUM_CTL-1:0][HDR_W-1:0] hdr_q;
  logic [NUM_CTL-1:0][DAT_W-1:0] dat_q;
  mem_wr_t           wr_q;

  logic       is_id, locked, addr_ok, soft_rst;
  logic [2:0] id_cmd, id_slot, cur_slot;

  assign is_id    = byte_i[BYTE_W-1];
  assign id_cmd   = byte_i[6:4];
  assign id_slot  = id_cmd - 3'd2;
  assign cur_slot = 3'(cmd_q) - 3'd2;
  assign locked   = (cmd_q == CMD_CHAR);
  assign addr_ok  = (row_q < ROW_W'(NUM_ROWS)) && (col_q < COL_W'(NUM_COLS));
  assign soft_rst = byte_vld_i && is_id && !locked &&
                    (id_cmd == 3'(CMD_C4)) && byte_i[SOFT_RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_ADDR;
      row_q  <= '0;
      col_q  <= '0;
      attr_q <= '0;
      hdr_q  <= '0;
      dat_q  <= '0;
      wr_q   <= '0;
    end else if (soft_rst) begin
      cmd_q  <= CMD_ADDR;
      row_q  <= '0;
      col_q  <= '0;
      attr_q <= '0;
      hdr_q  <= '0;
      dat_q  <= '0;
      wr_q   <= '0;
    end else begin
      wr_q.we <= 1'b0;
      if (fill_done_i) hdr_q[SYS_SLOT][FILL_BIT] <= 1'b0;
      if (byte_vld_i) begin
        if (is_id && !locked) begin
          cmd_q <= cmd_e'(id_cmd);
          case (cmd_e'(id_cmd))
            CMD_ADDR: row_q  <= byte_i[ROW_W-1:0];
            CMD_CHAR: attr_q <= byte_i[ATTR_W-1:0];
            default:  hdr_q[id_slot] <= byte_i[HDR_W-1:0];
          endcase
        end else begin
          case (cmd_q)
            CMD_ADDR: col_q <= byte_i[COL_W-1:0];
            CMD_CHAR: begin
              if (addr_ok) begin
                wr_q <= '{we: 1'b1, row: row_q, col: col_q, attr: attr_q,
                          code: byte_i[CODE_W-1:0]};
                if (col_q == COL_W'(NUM_COLS - 1)) begin
                  col_q <= '0;
                  row_q <= (row_q == ROW_W'(NUM_ROWS - 1)) ? '0 : row_q + 1'b1;
                end else begin
                  col_q <= col_q + 1'b1;
                end
              end
            end
            default: dat_q[cur_slot] <= byte_i[DAT_W-1:0];
          endcase
        end
      end
      if (cs_rise_i) cmd_q <= CMD_ADDR;
    end
  end

  assign wr_o  = wr_q;
  assign hdr_o = hdr_q;
  assign dat_o = dat_q;

  AST_SELECT_RETURNS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> cmd_q == CMD_ADDR); // R6
  AST_CHAR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_CHAR && !cs_rise_i) |=> cmd_q == CMD_CHAR); // R5
  AST_FILL_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_done_i && !(byte_vld_i && is_id)) |=> !hdr_q[SYS_SLOT][FILL_BIT]); // R11
  AST_BAD_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !addr_ok && !cs_rise_i) |=> (!wr_q.we && $stable(row_q) && $stable(col_q))); // R8
endmodule

// File: rtl/osd_fill.sv
module osd_fill
  import osd_cmd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    disp_on_i,
  input  logic    yield_i,
  output mem_wr_t wr_o,
  output logic    done_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic active, last_col, last_row;

  assign active   = req_i && !disp_on_i && !yield_i;
  assign last_col = (col_q == COL_W'(NUM_COLS - 1));
  assign last_row = (row_q == ROW_W'(NUM_ROWS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (!req_i) begin
      row_q <= '0;
      col_q <= '0;
    end else if (active) begin
      if (last_col) begin
        col_q <= '0;
        row_q <= last_row ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign wr_o   = '{we: active, row: row_q, col: col_q, attr: '0, code: BLANK_CODE};
  assign done_o = active && last_col && last_row;

  AST_FILL_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && disp_on_i) |=> (!req_i || ($stable(row_q) && $stable(col_q)))); // R11
endmodule

// File: rtl/osd_cmd_if.sv
module osd_cmd_if
  import osd_cmd_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_i,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  input  logic [HDR_W-1:0]           mode_pin_i,
  output logic                       mem_we_o,
  output logic [ROW_W-1:0]           mem_row_o,
  output logic [COL_W-1:0]           mem_col_o,
  output logic [ATTR_W-1:0]          mem_attr_o,
  output logic [CODE_W-1:0]          mem_code_o,
  output logic [NUM_CTL*HDR_W-1:0]   ctl_hdr_o,
  output logic [NUM_CTL*DAT_W-1:0]   ctl_dat_o,
  output logic [HDR_W-1:0]           mode_o
);
  logic              byte_vld, cs_rise, fill_done;
  logic [BYTE_W-1:0] rx_byte;
  mem_wr_t           dec_wr, fill_wr, mux_wr;
  logic [NUM_CTL-1:0][HDR_W-1:0] hdr;
  logic [NUM_CTL-1:0][DAT_W-1:0] dat;

  osd_ser_rx i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (cs_i),
    .sclk_i     (sclk_i),
    .sdi_i      (sdi_i),
    .byte_vld_o (byte_vld),
    .byte_o     (rx_byte),
    .cs_rise_o  (cs_rise)
  );

  osd_cmd_dec i_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld),
    .byte_i      (rx_byte),
    .cs_rise_i   (cs_rise),
    .fill_done_i (fill_done),
    .wr_o        (dec_wr),
    .hdr_o       (hdr),
    .dat_o       (dat)
  );

  osd_fill i_fill (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (hdr[SYS_SLOT][FILL_BIT]),
    .disp_on_i (dat[SYS_SLOT][DISP_BIT]),
    .yield_i   (dec_wr.we),
    .wr_o      (fill_wr),
    .done_o    (fill_done)
  );

  // character writes win; the fill retries the same cell next cycle
  assign mux_wr = dec_wr.we ? dec_wr : fill_wr;

  assign mem_we_o   = mux_wr.we;
  assign mem_row_o  = mux_wr.row;
  assign mem_col_o  = mux_wr.col;
  assign mem_attr_o = mux_wr.attr;
  assign mem_code_o = mux_wr.code;
  assign ctl_hdr_o  = hdr;
  assign ctl_dat_o  = dat;

  for (genvar b = 0; b < HDR_W; b++) begin : g_mode
    assign mode_o[b] = hdr[MODE_SLOT][b] | mode_pin_i[b];
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_row_o < ROW_W'(NUM_ROWS)) && (mem_col_o < COL_W'(NUM_COLS))); // R8
  AST_FILL_DISPLAY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !dec_wr.we) |-> !dat[SYS_SLOT][DISP_BIT]); // R11
endmodule

// File: tb/test_osd_cmd_if.sv
module test_osd_cmd_if;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [3:0] mode_pin = 4'h0;
  logic mem_we_o;
  logic [3:0] mem_row_o;
  logic [4:0] mem_col_o;
  logic [1:0] mem_attr_o;
  logic [6:0] mem_code_o;
  logic [23:0] ctl_hdr_o;
  logic [41:0] ctl_dat_o;
  logic [3:0] mode_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_cmd_if i_osd_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .mode_pin_i(mode_pin), .mem_we_o(mem_we_o), .mem_row_o(mem_row_o),
    .mem_col_o(mem_col_o), .mem_attr_o(mem_attr_o), .mem_code_o(mem_code_o),
    .ctl_hdr_o(ctl_hdr_o), .ctl_dat_o(ctl_dat_o), .mode_o(mode_o)
  );

  int n_chk = 0, n_fail = 0, n_wr = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural character memory
  logic [8:0] bm [12][24];
  always @(posedge clk)
    if (rst_n && mem_we_o) begin
      n_wr++;
      if (mem_row_o < 12 && mem_col_o < 24) bm[mem_row_o][mem_col_o] <= {mem_attr_o, mem_code_o};
    end

  // ---------------- reference model ----------------
  int m_cnt, m_cmd, m_row, m_col, m_attr, f_row, f_col;
  int e_row, e_col, e_attr, e_code;
  logic [7:0] m_sh, m_pb;
  logic m_pv, m_csp, m_sclkp, m_dwr, m_fwr, e_we;
  logic [5:0][3:0] m_hdr;
  logic [5:0][6:0] m_dat;
  logic f_req, f_done, c_rise, c_soft;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmd = 0; m_row = 0; m_col = 0; m_attr = 0; f_row = 0; f_col = 0;
      m_sh = 0; m_pb = 0; m_pv = 0; m_csp = 1; m_sclkp = 0; m_dwr = 0; m_fwr = 0;
      m_hdr = '0; m_dat = '0; e_we = 0; e_row = 0; e_col = 0; e_attr = 0; e_code = 0;
    end else begin
      // fill sequencer, acting on last cycle's state
      f_req = m_hdr[2][2];
      f_done = 0;
      if (!f_req) begin f_row = 0; f_col = 0; end
      else if (m_fwr) begin
        if (f_row == 11 && f_col == 23) f_done = 1;
        f_col++;
        if (f_col == 24) begin f_col = 0; f_row = (f_row == 11) ? 0 : f_row + 1; end
      end
      // command decode
      c_rise = cs && !m_csp;
      c_soft = m_pv && m_pb[7] && m_cmd != 1 && m_pb[6:4] == 3'd4 && m_pb[3];
      m_dwr = 0;
      if (c_soft) begin
        m_cmd = 0; m_row = 0; m_col = 0; m_attr = 0; m_hdr = '0; m_dat = '0;
      end else begin
        if (f_done) m_hdr[2][2] = 1'b0;
        if (m_pv) begin
          if (m_pb[7] && m_cmd != 1) begin
            m_cmd = int'(m_pb[6:4]);
            if (m_cmd == 0) m_row = int'(m_pb[3:0]);
            else if (m_cmd == 1) m_attr = int'(m_pb[1:0]);
            else m_hdr[m_cmd-2] = m_pb[3:0];
          end else if (m_cmd == 0) m_col = int'(m_pb[4:0]);
          else if (m_cmd == 1) begin
            if (m_row < 12 && m_col < 24) begin
              m_dwr = 1; e_row = m_row; e_col = m_col; e_attr = m_attr; e_code = int'(m_pb[6:0]);
              m_col++;
              if (m_col == 24) begin m_col = 0; m_row = (m_row == 11) ? 0 : m_row + 1; end
            end
          end else m_dat[m_cmd-2] = m_pb[6:0];
        end
        if (c_rise) m_cmd = 0;
      end
      // serial receive
      m_pv = 0;
      if (cs) m_cnt = 0;
      else if (sclk && !m_sclkp) begin
        m_sh = {m_sh[6:0], sdi};
        m_cnt++;
        if (m_cnt == 8) begin m_cnt = 0; m_pv = 1; m_pb = m_sh; end
      end
      m_csp = cs; m_sclkp = sclk;
      // outputs after this edge
      m_fwr = m_hdr[2][2] && !m_dat[2][0] && !m_dwr;
      e_we = m_dwr || m_fwr;
      if (!m_dwr && m_fwr) begin e_row = f_row; e_col = f_col; e_attr = 0; e_code = 127; end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk("R4 write strobe", 64'(mem_we_o), 64'(e_we));
      if (e_we && mem_we_o)
        chk("R7 write fields", {mem_row_o, mem_col_o, mem_attr_o, mem_code_o},
            {4'(e_row), 5'(e_col), 2'(e_attr), 7'(e_code)});
      chk("R9 control regs", {ctl_hdr_o, ctl_dat_o}, {m_hdr, m_dat});
      chk("R12 mode", 64'(mode_o), 64'(m_hdr[4] | mode_pin));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) begin sdi = b[i]; sclk = 1'b0; end
      @(negedge clk);
      @(negedge clk) sclk = 1'b1;
      @(negedge clk);
    end
    @(negedge clk) sclk = 1'b0;
  endtask
  task automatic send(input logic [7:0] b);
    send_bits(b, 8);
  endtask
  task automatic sel;
    @(negedge clk) cs = 1'b0;
  endtask
  task automatic desel;
    @(negedge clk) cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  int wr_before;

  initial begin
    for (int r = 0; r < 12; r++) for (int c = 0; c < 24; c++) bm[r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset hdr", 64'(ctl_hdr_o), 0);
    chk("R10 reset dat", 64'(ctl_dat_o), 0);
    chk("R10 reset strobe", 64'(mem_we_o), 0);

    // address, attributes, lock, advance
    sel; send(8'h82); send(8'h05); send(8'h93); send(8'h41); send(8'hC5); send(8'h10); desel;
    chk("R3 row/col placement", 64'(bm[2][5]), {2'b11, 7'h41});
    chk("R4 attributes+code", 64'(bm[2][5][8:7]), 2'b11);
    chk("R5 locked id as data", 64'(bm[2][6]), {2'b11, 7'h45});
    chk("R7 column advance", 64'(bm[2][7]), {2'b11, 7'h10});
    // select rise forces address mode: 0x05 sets column, not a character
    sel; send(8'h05); send(8'h91); send(8'h22); desel;
    chk("R6 back to address mode", 64'(bm[2][5]), {2'b01, 7'h22});
    chk("R6 no stray write", 64'(bm[2][8]), 0);

    // wrap at row/column ends
    sel; send(8'h8B); send(8'h16); send(8'h90); send(8'h31); send(8'h32); send(8'h33); desel;
    chk("R7 last row cell", 64'(bm[11][23]), {2'b00, 7'h32});
    chk("R7 wrap to origin", 64'(bm[0][0]), {2'b00, 7'h33});

    // out-of-range addresses
    wr_before = n_wr;
    sel; send(8'h8C); send(8'h03); send(8'h90); send(8'h55); send(8'h56); desel;
    sel; send(8'h81); send(8'h18); send(8'h90); send(8'h57); desel;
    chk("R8 no write out of range", 64'(n_wr), 64'(wr_before));
    sel; send(8'h81); send(8'h17); send(8'h90); send(8'h58); desel;
    chk("R8 legal edge cell", 64'(bm[1][23]), {2'b00, 7'h58});

    // partial byte dropped
    sel; send_bits(8'hFF, 4); desel;
    sel; send(8'h83); send(8'h02); send(8'h92); send(8'h60); desel;
    chk("R1 realigned after partial", 64'(bm[3][2]), {2'b10, 7'h60});

    // control registers and persistence
    sel; send(8'hA5); send(8'h2A); send(8'hD7); send(8'h55); send(8'h33); desel;
    chk("R9 cmd2 header", 64'(ctl_hdr_o[3:0]), 4'h5);
    chk("R9 cmd2 data", 64'(ctl_dat_o[6:0]), 7'h2A);
    chk("R9 cmd5 header", 64'(ctl_hdr_o[15:12]), 4'h7);
    chk("R2 selection persists", 64'(ctl_dat_o[27:21]), 7'h33);

    // mode merge
    mode_pin = 4'b1010;
    sel; send(8'hE5); desel;
    chk("R12 merged mode", 64'(mode_o), 4'b1111);
    mode_pin = 4'b0000;
    @(negedge clk);
    chk("R12 register only", 64'(mode_o), 4'b0101);

    // fill: held off while display on, then runs
    sel; send(8'hC0); send(8'h01); send(8'hC4); desel;
    repeat (30) @(negedge clk);
    chk("R11 paused while display on", 64'(bm[0][0]), {2'b00, 7'h33});
    chk("R11 request pending", 64'(ctl_hdr_o[11:8]), 4'h4);
    sel; send(8'hC4); send(8'h00); desel;
    sel; send(8'h85); send(8'h00); send(8'h90); send(8'h70); desel;
    repeat (400) @(negedge clk);
    chk("R11 last cell blank", 64'(bm[11][23]), {2'b00, 7'h7F});
    chk("R11 cell blank", 64'(bm[2][5]), {2'b00, 7'h7F});
    chk("R11 request cleared", 64'(ctl_hdr_o[11:8]), 4'h0);

    // soft clear
    sel; send(8'hC8); desel;
    chk("R10 soft clear hdr", 64'(ctl_hdr_o), 0);
    chk("R10 soft clear dat", 64'(ctl_dat_o), 0);

    // asynchronous reset
    sel; send(8'hA1); desel;
    chk("R9 header set", 64'(ctl_hdr_o[3:0]), 4'h1);
    #1 rst_n = 1'b0;
    #1 chk("R10 async clear", 64'(ctl_hdr_o), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule